// File: doc/BRIEF.md
# Octant Coil Drive Generator

This block turns a 10-bit pointer angle into a pair of signed drive codes for the two windings of an air-core gauge movement. One code feeds the sine winding and the other feeds the cosine winding, both through a downstream DAC. The circle is split into 1024 steps of roughly 0.35 degrees. The top three bits of the angle pick one of eight 45-degree octants, and the low seven bits give a position from 0 to 127 inside that octant.

The waveform is piecewise, not a true sinusoid. Inside every octant, one winding is held at positive or negative full scale while the other ramps between zero and full scale. The ramp follows a tangent curve, so the pointer moves at an even rate across the octant. The 128-point ramp is computed at elaboration time by a constant function. A new angle takes effect only on a clock edge where the load strobe is high. Between loads the outputs hold their last value.

The reset input asserts asynchronously and releases through a two-stage synchronizer. While reset is active, the outputs sit at the drive state for angle zero.

Top module: `gauge_coil_driver`

## Requirements
- R1: While reset is active, and until the first load after release, sin_o is 0 and cos_o is +511. A load strobe raised during reset is ignored.
- R2: Both outputs take a new value one clock edge after a rising edge at which load_i is high. On every edge with load_i low they keep their value, whatever angle_i does.
- R3: Bits 9:7 of angle_i select the octant. In octants 0, 3, 4 and 7 the sine output ramps and the cosine output has magnitude exactly 511. In octants 1, 2, 5 and 6 the cosine output ramps and the sine output has magnitude exactly 511.
- R4: The ramp magnitude equals round(511 × tan(k × 45° / 128)), within ±1. The index k is bits 6:0 of angle_i in even octants and 127 minus those bits in odd octants.
- R5: The sine output is positive or zero in octants 0–3 and negative or zero in octants 4–7. The cosine output is positive or zero in octants 0, 1, 6 and 7 and negative or zero in octants 2–5. A zero magnitude always gives the code 0.
- R6: The cardinal angles give exact (sine, cosine) pairs: code 0 gives (0, +511), code 256 gives (+511, 0), code 512 gives (0, −511), and code 768 gives (−511, 0).
- R7: At codes 128, 384, 640 and 896 both outputs have magnitude at least 500. Their (sine, cosine) signs are (+,+), (+,−), (−,−) and (−,+) in that order.
- R8: Code 1023 gives sine 0 and cosine +511.
- R9: Neither output ever takes the code −512. At least one output always has magnitude exactly 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| load_i | input | 1 | Load strobe; samples angle_i on the rising edge where it is high |
| angle_i | input | 10 | Pointer angle: bits 9:7 select the octant, bits 6:0 give the position in it |
| sin_o | output | 10 | Signed two's complement drive code for the sine winding |
| cos_o | output | 10 | Signed two's complement drive code for the cosine winding |

## Verification
The bench drives the octant seams first: the cardinal codes, the diagonal codes, and code 1023. There, a design with the ramp index running the wrong way would put a near-full ramp value where zero belongs, or a zero where the winding should be near full scale. A full sweep of all 1024 codes then compares every output against a tangent model computed with real arithmetic. That sweep exposes a swapped sign rule, a channel pinned in the wrong octant, or an off-by-one in the ramp table. Separate scenarios check the hold behaviour. The angle input is changed with the strobe low, and the outputs must not follow it. The strobe is also pulsed during reset, and it must not disturb the angle-zero state.

// File: rtl/gauge_pkg.sv
`timescale 1ns/1ps
package gauge_pkg;

  // pi in Q16 fixed point
  localparam longint PI_Q16 = 64'sd205887;

  // Per-octant control word produced by the octant decoder
  typedef struct packed {
    logic sin_ramp;  // 1: sine ramps, cosine pinned; 0: the reverse
    logic descend;   // 1: ramp index runs 127..0 across the octant
    logic sin_neg;   // sine channel negative
    logic cos_neg;   // cosine channel negative
  } oct_ctl_t;

  // Ramp magnitude for table index idx: full * tan(idx * (pi/4) / 2^pos_w).
  // Tangent by a [3/2] Pade form, a(15 - a^2) / (15 - 6 a^2), in Q16 integers.
  function automatic int ramp_mag(input int idx, input int pos_w, input int full);
    longint a;
    longint a2;
    longint num;
    longint den;
    longint t;
    longint fifteen;
    fifteen = 64'sd15 <<< 16;
    a   = (longint'(idx) * PI_Q16) / (longint'(4) <<< pos_w);
    a2  = (a * a) >>> 16;
    num = a * (fifteen - a2);
    den = fifteen - 64'sd6 * a2;
    t   = num / den;
    return int'((longint'(full) * t + 64'sd32768) >>> 16);
  endfunction

endpackage

// File: rtl/octant_decode.sv
`timescale 1ns/1ps
module octant_decode
  import gauge_pkg::*;
(
  input  logic [2:0] octant_i,
  output oct_ctl_t   ctl_o
);

  // Sine ramps where it passes through zero or approaches the diagonal from
  // its own full-scale side; signs follow the quadrant of the octant.
  always_comb begin
    ctl_o = '0;
    unique case (octant_i)
      3'd0: ctl_o = '{sin_ramp: 1'b1, descend: 1'b0, sin_neg: 1'b0, cos_neg: 1'b0};
      3'd1: ctl_o = '{sin_ramp: 1'b0, descend: 1'b1, sin_neg: 1'b0, cos_neg: 1'b0};
      3'd2: ctl_o = '{sin_ramp: 1'b0, descend: 1'b0, sin_neg: 1'b0, cos_neg: 1'b1};
      3'd3: ctl_o = '{sin_ramp: 1'b1, descend: 1'b1, sin_neg: 1'b0, cos_neg: 1'b1};
      3'd4: ctl_o = '{sin_ramp: 1'b1, descend: 1'b0, sin_neg: 1'b1, cos_neg: 1'b1};
      3'd5: ctl_o = '{sin_ramp: 1'b0, descend: 1'b1, sin_neg: 1'b1, cos_neg: 1'b1};
      3'd6: ctl_o = '{sin_ramp: 1'b0, descend: 1'b0, sin_neg: 1'b1, cos_neg: 1'b0};
      3'd7: ctl_o = '{sin_ramp: 1'b1, descend: 1'b1, sin_neg: 1'b1, cos_neg: 1'b0};
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/ramp_rom.sv
`timescale 1ns/1ps
module ramp_rom
  import gauge_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int MAG_W = 9
) (
  input  logic [POS_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o
);

  localparam int DEPTH = 1 << POS_W;
  localparam int FULL  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int VAL = ramp_mag(g, POS_W, FULL);
    assign tbl[g] = MAG_W'(VAL);
  end

  assign mag_o = tbl[idx_i];

endmodule

// File: rtl/coil_mux.sv
`timescale 1ns/1ps
module coil_mux
  import gauge_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  oct_ctl_t                ctl_i,
  input  logic [OUT_W-2:0]        ramp_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int MAG_W = OUT_W - 1;
  localparam logic [MAG_W-1:0] FULL_MAG = {MAG_W{1'b1}};

  logic [MAG_W-1:0]        sin_mag;
  logic [MAG_W-1:0]        cos_mag;
  logic signed [OUT_W-1:0] sin_pos;
  logic signed [OUT_W-1:0] cos_pos;

  always_comb begin
    sin_mag = ctl_i.sin_ramp ? ramp_i : FULL_MAG;
    cos_mag = ctl_i.sin_ramp ? FULL_MAG : ramp_i;
    sin_pos = $signed({1'b0, sin_mag});
    cos_pos = $signed({1'b0, cos_mag});
    sin_o   = ctl_i.sin_neg ? -sin_pos : sin_pos;
    cos_o   = ctl_i.cos_neg ? -cos_pos : cos_pos;
  end

  // The ramp table must never reach full scale, or both windings would pin.
  always_comb begin
    assert_ramp_below_full_R4: assert (ramp_i != FULL_MAG)
      else $error("ramp table reached full scale");
  end

endmodule

// File: rtl/gauge_coil_driver.sv
`timescale 1ns/1ps
module gauge_coil_driver
  import gauge_pkg::*;
#(
  parameter int ANGLE_W = 10,
  parameter int OUT_W   = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [ANGLE_W-1:0]        angle_i,
  output logic signed [OUT_W-1:0]   sin_o,
  output logic signed [OUT_W-1:0]   cos_o
);

  localparam int OCT_W = 3;
  localparam int POS_W = ANGLE_W - OCT_W;
  localparam int MAG_W = OUT_W - 1;
  localparam logic signed [OUT_W-1:0] POS_FULL = $signed({1'b0, {MAG_W{1'b1}}});
  localparam logic signed [OUT_W-1:0] NEG_FULL = -POS_FULL;
  localparam logic signed [OUT_W-1:0] MOST_NEG = $signed({1'b1, {MAG_W{1'b0}}});

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  // ---------------- angle datapath ----------------
  logic [OCT_W-1:0]        octant;
  logic [POS_W-1:0]        pos;
  logic [POS_W-1:0]        ramp_idx;
  logic [MAG_W-1:0]        ramp_mag_w;
  oct_ctl_t                ctl;
  logic signed [OUT_W-1:0] sin_new;
  logic signed [OUT_W-1:0] cos_new;

  assign octant   = angle_i[ANGLE_W-1 -: OCT_W];
  assign pos      = angle_i[POS_W-1:0];
  // descending index is (2^POS_W - 1) - pos
  assign ramp_idx = ctl.descend ? ~pos : pos;

  octant_decode u_decode (
    .octant_i (octant),
    .ctl_o    (ctl)
  );

  ramp_rom #(.POS_W(POS_W), .MAG_W(MAG_W)) u_rom (
    .idx_i (ramp_idx),
    .mag_o (ramp_mag_w)
  );

  coil_mux #(.OUT_W(OUT_W)) u_mux (
    .ctl_i  (ctl),
    .ramp_i (ramp_mag_w),
    .sin_o  (sin_new),
    .cos_o  (cos_new)
  );

  // ---------------- output registers ----------------
  logic signed [OUT_W-1:0] sin_q, sin_d;
  logic signed [OUT_W-1:0] cos_q, cos_d;

  always_comb begin
    sin_d = sin_q;
    cos_d = cos_q;
    if (load_i) begin
      sin_d = sin_new;
      cos_d = cos_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      sin_q <= '0;
      cos_q <= POS_FULL;
    end else begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;

  // ---------------- assertions ----------------
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !load_i |=> ($stable(sin_o) && $stable(cos_o)))
    else $error("outputs changed without load");

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (sin_o != MOST_NEG) && (cos_o != MOST_NEG))
    else $error("output reached most negative code");

  assert_one_pinned_R9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (sin_o == POS_FULL) || (sin_o == NEG_FULL) || (cos_o == POS_FULL) || (cos_o == NEG_FULL))
    else $error("no channel at full scale");

  assert_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (load_i && angle_i == '0) |=> (sin_o == '0 && cos_o == POS_FULL))
    else $error("angle zero drive wrong");

  assert_quarter_R6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (load_i && angle_i == ANGLE_W'(1 << (ANGLE_W - 2))) |=> (sin_o == POS_FULL && cos_o == '0))
    else $error("quarter turn drive wrong");

  assert_half_R6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (load_i && angle_i == ANGLE_W'(1 << (ANGLE_W - 1))) |=> (sin_o == '0 && cos_o == NEG_FULL))
    else $error("half turn drive wrong");

endmodule

// File: tb/gauge_coil_driver_tb_top.sv
`timescale 1ns/1ps
module gauge_coil_driver_tb_top;

  logic              clk;
  logic              rst_n;
  logic              load;
  logic [9:0]        angle;
  logic signed [9:0] sin_o;
  logic signed [9:0] cos_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  gauge_coil_driver dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load),
    .angle_i (angle),
    .sin_o   (sin_o),
    .cos_o   (cos_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- model ----------------
  function automatic int model_mag(input int k);
    real r;
    r = 511.0 * $tan(real'(k) * 3.14159265358979 / 512.0);
    return $rtoi(r + 0.5);
  endfunction

  // returns expected sine, cosine and whether sine is the ramping channel
  task automatic model(input int code, output int s, output int c, output bit s_ramps);
    int oct;
    int p;
    int k;
    int m;
    oct = code / 128;
    p   = code % 128;
    k   = (oct % 2 == 1) ? 127 - p : p;
    m   = model_mag(k);
    s_ramps = (oct == 0 || oct == 3 || oct == 4 || oct == 7);
    s = s_ramps ? m : 511;
    c = s_ramps ? 511 : m;
    if (oct >= 4) s = -s;
    if (oct >= 2 && oct <= 5) c = -c;
  endtask

  // ---------------- check helpers ----------------
  task automatic check(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    n_run++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_code(input int code);
    @(negedge clk);
    angle = 10'(code);
    load  = 1'b1;
    @(negedge clk);
    load  = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    load  = 1'b0;
    angle = '0;
    repeat (3) @(negedge clk);
    angle = 10'd256;
    load  = 1'b1;          // R1: strobe during reset must be ignored
    repeat (2) @(negedge clk);
    check("R1", "sin during reset", int'(sin_o), 0, 0);
    check("R1", "cos during reset", int'(cos_o), 511, 0);
    load  = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "sin after release", int'(sin_o), 0, 0);
    check("R1", "cos after release", int'(cos_o), 511, 0);
  endtask

  task automatic t_hold();
    int s, c;
    bit r;
    load_code(300);
    model(300, s, c, r);
    check("R2", "sin after load 300", int'(sin_o), s, 1);
    check("R2", "cos after load 300", int'(cos_o), c, 1);
    @(negedge clk);
    angle = 10'd700;       // load low: no effect
    repeat (3) @(negedge clk);
    angle = 10'd5;
    repeat (2) @(negedge clk);
    check("R2", "sin held", int'(sin_o), s, 1);
    check("R2", "cos held", int'(cos_o), c, 1);
  endtask

  task automatic t_cardinal();
    load_code(0);
    check("R6", "sin @0", int'(sin_o), 0, 0);
    check("R6", "cos @0", int'(cos_o), 511, 0);
    load_code(256);
    check("R6", "sin @256", int'(sin_o), 511, 0);
    check("R6", "cos @256", int'(cos_o), 0, 0);
    load_code(512);
    check("R6", "sin @512", int'(sin_o), 0, 0);
    check("R6", "cos @512", int'(cos_o), -511, 0);
    load_code(768);
    check("R6", "sin @768", int'(sin_o), -511, 0);
    check("R6", "cos @768", int'(cos_o), 0, 0);
  endtask

  task automatic t_diagonal();
    int codes[4] = '{128, 384, 640, 896};
    int ss[4]    = '{1, 1, -1, -1};
    int cs[4]    = '{1, -1, -1, 1};
    for (int i = 0; i < 4; i++) begin
      load_code(codes[i]);
      check("R7", $sformatf("sin sign @%0d", codes[i]), (sin_o > 0) ? 1 : -1, ss[i], 0);
      check("R7", $sformatf("cos sign @%0d", codes[i]), (cos_o > 0) ? 1 : -1, cs[i], 0);
      check("R7", $sformatf("sin mag>=500 @%0d", codes[i]),
            ((sin_o >= 500) || (sin_o <= -500)) ? 1 : 0, 1, 0);
      check("R7", $sformatf("cos mag>=500 @%0d", codes[i]),
            ((cos_o >= 500) || (cos_o <= -500)) ? 1 : 0, 1, 0);
    end
  endtask

  task automatic t_last();
    load_code(1023);
    check("R8", "sin @1023", int'(sin_o), 0, 0);
    check("R8", "cos @1023", int'(cos_o), 511, 0);
  endtask

  task automatic t_sweep();
    int s, c;
    bit r;
    for (int code = 0; code < 1024; code++) begin
      load_code(code);
      model(code, s, c, r);
      // R3: pinned channel exact; R4/R5: ramp channel within one step, signed
      check(r ? "R4" : "R3", $sformatf("sin @%0d", code), int'(sin_o), s, r ? 1 : 0);
      check(r ? "R3" : "R4", $sformatf("cos @%0d", code), int'(cos_o), c, r ? 0 : 1);
      check("R5", $sformatf("sin sign @%0d", code),
            (code >= 512) ? ((sin_o <= 0) ? 1 : 0) : ((sin_o >= 0) ? 1 : 0), 1, 0);
      check("R9", $sformatf("no -512 @%0d", code),
            ((sin_o != -512) && (cos_o != -512)) ? 1 : 0, 1, 0);
    end
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    t_hold();
    t_cardinal();
    t_diagonal();
    t_last();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule